// File: doc/BRIEF.md
# PHY Management Interface Master

This block lets on-chip logic read and write the registers of an external Ethernet PHY over the two-wire management interface. It divides the system clock to produce the management clock MDC. It serialises one clause-22 frame per command on the MDIO line, and it captures the 16 data bits the PHY returns on a read.

Software-style control is a single command word. The PHY address and the write data come from their own inputs and are latched when a command is accepted. Writing the command word with its start bit set launches a frame. The start bit then reads back as 1 for as long as the frame runs, which makes it the busy indicator. A one-cycle completion pulse marks the end of every frame. MDIO is presented as separate output, output-enable and input pins, so the pad ring can build the open line.

Top module: `mdio_master`

## Requirements
- R1: MDC runs continuously with a period of exactly 2*(div_i+1) system clock cycles. It is high for div_i+1 cycles and low for div_i+1 cycles, and it is low out of reset.
- R2: Writing the command word (ctrl_we_i) with bit 0 set while idle starts a frame. Bit 0 of ctrl_rdata_o reads 1 from the next cycle until the frame ends and then returns to 0. MDIO is driven only while bit 0 reads 1.
- R3: Command bit 1 selects the operation. A value of 1 sends opcode 01 (write) and a value of 0 sends opcode 10 (read).
- R4: A frame is 64 MDC periods, in this order: 32 ones, start bits 01, the 2-bit opcode, phy_addr_i (5 bits), then the register address taken from command bits 7:3 (5 bits), a 2-bit turnaround and 16 data bits, every field MSB first. A write sends turnaround 10 and tx_data_i. Command bits 7:3 and bit 1 read back at the same positions on ctrl_rdata_o, and bit 2 reads 0.
- R5: On a read, the master stops driving MDIO from the first turnaround bit to the end of the frame. It samples the 16 data bits on MDC rising edges and loads them into rx_data_o, first bit in bit 15, in the cycle the frame ends. rx_data_o changes at no other time.
- R6: mdio_o and mdio_oe_o change only together with a falling edge of MDC.
- R7: done_o is a single-cycle pulse, raised in the same cycle the busy bit clears.
- R8: A command write with bit 0 set while a frame is running is ignored. The running frame, the command read-back and the transaction count are unaffected.
- R9: Under reset, MDC is 0, MDIO is not driven, the busy bit reads 0, done_o is 0 and rx_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 8 | MDC divider value |
| phy_addr_i | input | 5 | PHY address used by each frame |
| tx_data_i | input | 16 | Data sent by write frames |
| ctrl_we_i | input | 1 | Command word write strobe |
| ctrl_wdata_i | input | 8 | Command word: bit 0 start, bit 1 write, bits 7:3 register address |
| ctrl_rdata_o | output | 8 | Command read-back; bit 0 is busy |
| rx_data_o | output | 16 | Data returned by the last read frame |
| done_o | output | 1 | Frame completion pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions assume that div_i is held constant while a frame runs. They also assume that the PHY drives the line only from the second turnaround bit of a read to the end of that frame, changing it after MDC falls. The bench changes the divider only between frames, when the busy bit reads 0. Its PHY responder updates its output only on MDC falling edges and only inside that window. The bench also counts any cycle in which both sides drive the line and reports it as a failure.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CTRL_START   = 0;
  localparam int CTRL_WRITE   = 1;
  localparam int CTRL_REG_LSB = 3;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  // >= so a divider lowered mid-count cannot stall the counter
  assign tick = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int FRAME_W = PRE_BITS + 6 + 2*ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int TA_POS  = FRAME_W - DATA_W - 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               busy_q, live_q, wr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rsh_q;
  logic [FRAME_W-1:0] frame_d;

  assign frame_d = {{PRE_BITS{1'b1}}, SOF, (wr_i ? OP_WR : OP_RD), phy_i, reg_i,
                    (wr_i ? TA_WR : 2'b00), (wr_i ? wdata_i : {DATA_W{1'b0}})};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      live_q    <= 1'b0;
      wr_q      <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        live_q <= 1'b0;
        wr_q   <= wr_i;
        cnt_q  <= '0;
        sh_q   <= frame_d;
      end else if (busy_q && fall_i) begin
        if (!live_q) begin
          // first falling edge after acceptance puts bit 0 on the line
          live_q    <= 1'b1;
          mdio_o    <= sh_q[FRAME_W-1];
          mdio_oe_o <= 1'b1;
        end else if (cnt_q == LAST) begin
          busy_q    <= 1'b0;
          live_q    <= 1'b0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
          done_o    <= 1'b1;
          if (!wr_q) rdata_o <= rsh_q;
        end else begin
          cnt_q     <= cnt_q + 1'b1;
          sh_q      <= {sh_q[FRAME_W-2:0], 1'b0};
          mdio_o    <= sh_q[FRAME_W-2];
          mdio_oe_o <= wr_q || (int'(cnt_q) + 1 < TA_POS);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsh_q <= '0;
    end else if (rise_i && live_q && !wr_q && int'(cnt_q) >= TA_POS + 2) begin
      rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_BITS = 32,
  localparam int CTRL_W  = CTRL_REG_LSB + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic rise, fall, busy, start;
  logic [ADDR_W-1:0] reg_q;
  logic              wr_q;

  assign start = ctrl_we_i & ctrl_wdata_i[CTRL_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      wr_q  <= 1'b0;
    end else if (start && !busy) begin
      reg_q <= ctrl_wdata_i[CTRL_W-1:CTRL_REG_LSB];
      wr_q  <= ctrl_wdata_i[CTRL_WRITE];
    end
  end

  assign ctrl_rdata_o = {reg_q, 1'b0, wr_q, busy};

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .wr_i     (ctrl_wdata_i[CTRL_WRITE]),
    .phy_i    (phy_addr_i),
    .reg_i    (ctrl_wdata_i[CTRL_W-1:CTRL_REG_LSB]),
    .wdata_i  (tx_data_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rdata_o  (rx_data_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CTRL_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              done_o,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o
);
  logic busy;
  assign busy = ctrl_rdata_o[0];

  assert_oe_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);

  assert_out_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> $fell(mdc_o));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);

  assert_busy_end_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_we_i && ctrl_wdata_i[0]) |=> $stable(ctrl_rdata_o[CTRL_W-1:1]));

  assert_rx_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> done_o);
endmodule

bind mdio_master mdio_master_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .rx_data_o   (rx_data_o),
  .done_o      (done_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = 8'd1;
  logic [4:0]  phy = '0;
  logic [15:0] txd = '0;
  logic        we = 1'b0;
  logic [7:0]  wdat = '0;
  logic [7:0]  rdat;
  logic [15:0] rxd;
  logic        done, mdc, mdo, moe, bus;

  logic        phy_oe = 1'b0, phy_out = 1'b1, phy_rd = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap = '0;
  int          k = 0;
  int          oe_bad = 0, clash = 0, r6_bad = 0, done_cnt = 0;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        mdc_d = 1'b0, mdo_d = 1'b1, moe_d = 1'b0;

  always #4 clk = ~clk;

  assign bus = moe ? mdo : (phy_oe ? phy_out : 1'b1);

  mdio_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .phy_addr_i(phy), .tx_data_i(txd),
    .ctrl_we_i(we), .ctrl_wdata_i(wdat), .ctrl_rdata_o(rdat), .rx_data_o(rxd),
    .done_o(done), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(bus)
  );

  // PHY responder: capture on MDC rise, drive on MDC fall
  always @(posedge mdc) begin
    if ((k > 0 || moe) && k < 64) begin
      cap = {cap[62:0], bus};
      if (phy_rd && k >= 46 && moe) oe_bad++;
      k++;
    end
  end
  always @(negedge mdc) begin
    if (phy_rd && k >= 47 && k <= 63) begin
      phy_oe  = 1'b1;
      phy_out = (k == 47) ? 1'b0 : phy_val[63-k];
    end else begin
      phy_oe  = 1'b0;
      phy_out = 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (moe && phy_oe) clash++;
    if (rst_n && (mdo !== mdo_d || moe !== moe_d) && !(mdc_d && !mdc)) r6_bad++;
    if (done) done_cnt++;
    mdc_d = mdc; mdo_d = mdo; moe_d = moe;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=%0d exp<150000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [4:0] ra);
    @(negedge clk);
    we = 1'b1; wdat = {ra, 1'b0, wr, 1'b1};
    @(negedge clk);
    we = 1'b0; wdat = '0;
  endtask

  task automatic wait_done(output int w);
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
  endtask

  task automatic t_reset();
    #1;
    chk(mdc == 0 && moe == 0, "R9 line idle", {mdc, moe}, 0);
    chk(rdat[0] == 0 && done == 0, "R9 busy/done", {rdat[0], done}, 0);
    chk(rxd == 0, "R9 rx_data", rxd, 0);
  endtask

  task automatic t_period(input logic [7:0] d);
    int hi, lo;
    div = d;
    @(negedge clk);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    hi = 0; while (mdc) begin hi++; @(negedge clk); end
    lo = 0; while (!mdc) begin lo++; @(negedge clk); end
    chk(hi == d + 1 && lo == d + 1, "R1 MDC high/low", {hi[31:0], lo[31:0]}, {32'(d + 1), 32'(d + 1)});
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] dat);
    int w, dc;
    logic [63:0] exp;
    phy = pa; txd = dat; phy_rd = 1'b0; k = 0;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, dat};
    dc = done_cnt;
    issue(1'b1, ra);
    chk(rdat[0] == 1, "R2 busy set", rdat[0], 1);
    chk(rdat[7:1] == {ra, 2'b01}, "R4 reg field readback", rdat[7:1], {ra, 2'b01});
    wait_done(w);
    chk(w < 5000 && rdat[0] == 0, "R7 done with busy clear", {w[31:0], 31'd0, rdat[0]}, 0);
    @(negedge clk);
    chk(done == 0 && done_cnt == dc + 1, "R7 single pulse", done_cnt, dc + 1);
    chk(k == 64, "R4 frame length", k, 64);
    chk(cap == exp, "R3/R4 write frame", cap, exp);
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] val);
    int w, ob;
    logic [45:0] hdr;
    phy = pa; phy_val = val; phy_rd = 1'b1; k = 0; ob = oe_bad;
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
    issue(1'b0, ra);
    chk(rdat[0] == 1 && rdat[1] == 0, "R2/R3 read busy", rdat[1:0], 2'b01);
    wait_done(w);
    chk(rxd == val, "R5 read data", rxd, val);
    chk(cap[63:18] == hdr, "R3/R4 read header", cap[63:18], hdr);
    chk(oe_bad == ob, "R5 released in turnaround/data", oe_bad, ob);
    @(negedge clk);
    phy_rd = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int w;
    logic [63:0] exp;
    int dc;
    phy = 5'h0b; txd = 16'h1234; phy_rd = 1'b0; k = 0;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0b, 5'h04, 2'b10, 16'h1234};
    issue(1'b1, 5'h04);
    repeat (30) @(negedge clk);
    txd = 16'hFFFF; phy = 5'h1f;
    issue(1'b0, 5'h1d);
    chk(rdat[7:1] == {5'h04, 2'b01}, "R8 readback unchanged", rdat[7:1], {5'h04, 2'b01});
    dc = done_cnt;
    wait_done(w);
    chk(cap == exp, "R8 frame unchanged", cap, exp);
    repeat (300) @(negedge clk);
    chk(rdat[0] == 0 && done_cnt == dc + 1, "R8 no extra frame", done_cnt, dc + 1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_period(8'd1);
    t_period(8'd4);
    t_period(8'd0);
    div = 8'd1;
    t_write(5'h13, 5'h0a, 16'hA5C3);
    t_read(5'h01, 5'h1f, 16'h3C96);
    div = 8'd3;
    t_read(5'h1e, 5'h02, 16'h8001);
    t_write(5'h00, 5'h11, 16'h0000);
    div = 8'd0;
    t_read(5'h15, 5'h0f, 16'hFFFF);
    t_busy_ignore();
    chk(clash == 0, "R5 no line contention", clash, 0);
    chk(r6_bad == 0, "R6 output only on MDC fall", r6_bad, 0);
    summary();
  end
endmodule